// File: doc/BRIEF.md
# Micro-op Dispatch Throttle with Carry-over

This block is the per-cycle admission gate in front of the scheduler of an out-of-order core model. Each cycle it is offered at most one instruction, described by a micro-op count, an identifier and a flag that marks the instruction as dependency-breaking. The block has a budget of micro-op slots per cycle equal to the dispatch width. It decides in the same cycle whether the offered instruction may pass. It holds no instruction storage of its own, so an instruction is taken only when it can be handed to the next stage at once.

An instruction may be taken only if its slot demand fits the remaining budget and three outside conditions hold. Those conditions are checked in a fixed order: room in the retire buffer for all of its micro-ops, a register-file allocation for its destinations, and a ready next stage. The first condition that fails is reported as the stall cause. On acceptance the block forwards the identifier, requests retire-buffer slots, emits a dispatch event and, unless the instruction breaks dependencies, requests a dependency update.

An instruction wider than the dispatch width uses the whole budget of its own cycle. The remaining micro-ops are charged against the budgets of the cycles that follow, and each of those cycles reports a partial-dispatch event for the held instruction.

Top module: `uop_dispatch_gate`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `avail_slots` equals the dispatch width W (default 4), `carry_pending` and `part_evt_valid` are 0, and any carry-over in progress is discarded.
- R2: A cycle that follows a cycle with no remaining carry-over and no oversized acceptance starts with `avail_slots` = W and no partial event.
- R3: The effective micro-op count is `in_uops`, or 1 when `in_uops` is 0. The slot demand is the smaller of the effective count and W. `in_ready` is 1 only when the slot demand is at most `avail_slots`, and an instruction is accepted (`fwd_valid` = 1) only when `in_valid` and `in_ready` are both 1.
- R4: With `in_valid` high and the slot demand fitting, the conditions are tested in order. If `rob_free` is below the effective count, `stall_code` = 2'b01 (retire buffer). Otherwise, if `rf_ok` is 0, `stall_code` = 2'b10 (register file). In all other cases `stall_code` = 2'b00, and that includes a slot shortfall.
- R5: When `next_rdy` is 0, nothing is accepted and no stall code is raised for that reason alone.
- R6: On acceptance `fwd_id` = `in_id`, `rob_rsv_count` equals the effective count, and `disp_evt_uops` equals the slot demand. These outputs are 0 in a cycle with no acceptance.
- R7: Accepting an instruction whose effective count E exceeds W stores E−W as carry-over for the held identifier.
- R8: At the start of each later cycle with carry-over C, consumed = min(C, W). `avail_slots` = W − consumed, C is reduced by consumed, and `part_evt_valid` = 1 with `part_evt_uops` = consumed and `part_evt_id` = the held identifier.
- R9: `carry_pending` is 1 while carry-over remains after the current cycle's charge. An oversized instruction is never accepted while it is 1, and after the last partial event the next cycle returns to the full budget.
- R10: `dep_upd_req` is 1 on acceptance of an instruction with `in_dep_break` = 0, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered |
| in_uops | input | 4 | Micro-op count of the offered instruction |
| in_id | input | 8 | Identifier of the offered instruction |
| in_dep_break | input | 1 | Offered instruction breaks dependencies |
| rob_free | input | 5 | Free retire-buffer entries |
| rf_ok | input | 1 | Register file can allocate the destinations |
| next_rdy | input | 1 | Next stage can take an instruction this cycle |
| in_ready | output | 1 | The offered instruction would be accepted |
| stall_code | output | 2 | 00 none, 01 retire buffer, 10 register file |
| fwd_valid | output | 1 | Instruction accepted and forwarded |
| fwd_id | output | 8 | Identifier forwarded |
| dep_upd_req | output | 1 | Request a dependency update for the sources |
| rob_rsv_count | output | 4 | Retire-buffer slots to reserve |
| disp_evt_uops | output | 3 | Micro-ops reported for the acceptance cycle |
| part_evt_valid | output | 1 | Partial dispatch of a carried instruction |
| part_evt_uops | output | 3 | Micro-ops charged this cycle to the carried instruction |
| part_evt_id | output | 8 | Identifier of the carried instruction |
| avail_slots | output | 3 | Slots left for new work this cycle |
| carry_pending | output | 1 | Carry-over remains after this cycle |

## Verification
The assertions check the properties that hold on every cycle: an acceptance always fits the remaining budget and has a ready next stage, a stall code appears only on a refused offer, a partial event and the free slots always add up to the width, an oversized acceptance is followed by a partial event of the right size, and dependency-breaking instructions never raise the update request. The stall priority, with the retire buffer tested before the register file, the exact carry-over arithmetic over several cycles, the identifier held across partial events, and the discarding of carry-over by reset can only be shown by the bench's ordered scenarios, because they depend on a known history.

// File: rtl/uop_dispatch_pkg.sv
package uop_dispatch_pkg;

  // Stall cause reported on a refused offer; order of checks is retire, regfile, next.
  typedef enum logic [1:0] {
    STALL_NONE    = 2'b00,
    STALL_RETIRE  = 2'b01,
    STALL_REGFILE = 2'b10
  } stall_e;

endpackage

// File: rtl/dispatch_budget.sv
// Slot budget and carry-over state. The register values describe the state
// after the start-of-cycle charge of any carried instruction.
module dispatch_budget #(
  parameter int W     = 4,
  parameter int UOP_W = 4,
  parameter int ID_W  = 8,
  parameter int SW    = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [UOP_W-1:0] acc_eff,
  input  logic [ID_W-1:0]  acc_id,
  output logic [SW-1:0]    avail,
  output logic             carry_pend,
  output logic             part_valid,
  output logic [SW-1:0]    part_uops,
  output logic [ID_W-1:0]  part_id
);

  localparam logic [UOP_W-1:0] W_U  = UOP_W'(W);
  localparam logic [SW-1:0]    W_S  = SW'(W);

  logic [UOP_W-1:0] carry_q, carry_d;
  logic [SW-1:0]    avail_q, avail_d;
  logic             pv_q, pv_d;
  logic [SW-1:0]    pu_q, pu_d;
  logic [ID_W-1:0]  pid_q, pid_d;
  logic [ID_W-1:0]  held_q, held_d;
  logic             held_en;

  logic             oversized;
  logic [UOP_W-1:0] carry_mid;
  logic [UOP_W-1:0] consumed;

  // Next-state: apply this cycle's acceptance, then the next cycle's charge.
  always_comb begin
    oversized = acc && (acc_eff > W_U);
    carry_mid = oversized ? (acc_eff - W_U) : carry_q;
    consumed  = (carry_mid >= W_U) ? W_U : carry_mid;
    carry_d   = carry_mid - consumed;
    avail_d   = W_S - SW'(consumed);
    pv_d      = (carry_mid != '0);
    pu_d      = SW'(consumed);
    pid_d     = oversized ? acc_id : held_q;
    held_en   = oversized || (carry_q != '0);
    held_d    = (carry_d != '0) ? pid_d : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= '0;
      avail_q <= W_S;
      pv_q    <= 1'b0;
      pu_q    <= '0;
      pid_q   <= '0;
    end else begin
      carry_q <= carry_d;
      avail_q <= avail_d;
      pv_q    <= pv_d;
      pu_q    <= pu_d;
      pid_q   <= pv_d ? pid_d : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end

  assign avail      = avail_q;
  assign carry_pend = (carry_q != '0);
  assign part_valid = pv_q;
  assign part_uops  = pu_q;
  assign part_id    = pid_q;

endmodule

// File: rtl/dispatch_arbiter.sv
// Combinational admission decision and stall cause for the offered instruction.
module dispatch_arbiter
  import uop_dispatch_pkg::*;
#(
  parameter int W     = 4,
  parameter int UOP_W = 4,
  parameter int ROB_W = 5,
  parameter int SW    = $clog2(W + 1)
) (
  input  logic             in_valid,
  input  logic [UOP_W-1:0] in_uops,
  input  logic [ROB_W-1:0] rob_free,
  input  logic             rf_ok,
  input  logic             next_rdy,
  input  logic [SW-1:0]    avail,
  input  logic             carry_pend,
  output logic [UOP_W-1:0] eff,
  output logic [SW-1:0]    need,
  output logic             ready,
  output stall_e           stall
);

  localparam int CW = (ROB_W > UOP_W) ? ROB_W : UOP_W;
  localparam logic [UOP_W-1:0] W_U = UOP_W'(W);

  logic slots_ok, over_ok, rob_ok, gate_ok;

  always_comb begin
    eff      = (in_uops == '0) ? UOP_W'(1) : in_uops;
    need     = (eff > W_U) ? SW'(W) : SW'(eff);
    slots_ok = (need <= avail);
    over_ok  = !((eff > W_U) && carry_pend);
    gate_ok  = slots_ok && over_ok;
    rob_ok   = (CW'(rob_free) >= CW'(eff));
    ready    = gate_ok && rob_ok && rf_ok && next_rdy;
    stall    = STALL_NONE;
    if (in_valid && gate_ok) begin
      if (!rob_ok)     stall = STALL_RETIRE;
      else if (!rf_ok) stall = STALL_REGFILE;
    end
  end

endmodule

// File: rtl/uop_dispatch_gate.sv
module uop_dispatch_gate
  import uop_dispatch_pkg::*;
#(
  parameter int W     = 4,
  parameter int UOP_W = 4,
  parameter int ID_W  = 8,
  parameter int ROB_W = 5,
  parameter int SW    = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [UOP_W-1:0] in_uops,
  input  logic [ID_W-1:0]  in_id,
  input  logic             in_dep_break,
  input  logic [ROB_W-1:0] rob_free,
  input  logic             rf_ok,
  input  logic             next_rdy,
  output logic             in_ready,
  output logic [1:0]       stall_code,
  output logic             fwd_valid,
  output logic [ID_W-1:0]  fwd_id,
  output logic             dep_upd_req,
  output logic [UOP_W-1:0] rob_rsv_count,
  output logic [SW-1:0]    disp_evt_uops,
  output logic             part_evt_valid,
  output logic [SW-1:0]    part_evt_uops,
  output logic [ID_W-1:0]  part_evt_id,
  output logic [SW-1:0]    avail_slots,
  output logic             carry_pending
);

  logic [UOP_W-1:0] eff;
  logic [SW-1:0]    need;
  logic [SW-1:0]    avail;
  logic             carry_pend;
  logic             ready;
  logic             acc;
  stall_e           stall;

  dispatch_arbiter #(.W(W), .UOP_W(UOP_W), .ROB_W(ROB_W), .SW(SW)) u_arb (
    .in_valid   (in_valid),
    .in_uops    (in_uops),
    .rob_free   (rob_free),
    .rf_ok      (rf_ok),
    .next_rdy   (next_rdy),
    .avail      (avail),
    .carry_pend (carry_pend),
    .eff        (eff),
    .need       (need),
    .ready      (ready),
    .stall      (stall)
  );

  assign acc = in_valid && ready;

  dispatch_budget #(.W(W), .UOP_W(UOP_W), .ID_W(ID_W), .SW(SW)) u_bud (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .acc_eff    (eff),
    .acc_id     (in_id),
    .avail      (avail),
    .carry_pend (carry_pend),
    .part_valid (part_evt_valid),
    .part_uops  (part_evt_uops),
    .part_id    (part_evt_id)
  );

  always_comb begin
    in_ready      = ready;
    stall_code    = stall;
    fwd_valid     = acc;
    fwd_id        = acc ? in_id : '0;
    dep_upd_req   = acc && !in_dep_break;
    rob_rsv_count = acc ? eff : '0;
    disp_evt_uops = acc ? need : '0;
    avail_slots   = avail;
    carry_pending = carry_pend;
  end

endmodule

// File: rtl/uop_dispatch_gate_chk.sv
module uop_dispatch_gate_chk #(
  parameter int W     = 4,
  parameter int UOP_W = 4,
  parameter int ID_W  = 8,
  parameter int ROB_W = 5,
  parameter int SW    = $clog2(W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [UOP_W-1:0] in_uops,
  input logic             in_dep_break,
  input logic [ROB_W-1:0] rob_free,
  input logic             next_rdy,
  input logic             in_ready,
  input logic [1:0]       stall_code,
  input logic             fwd_valid,
  input logic             dep_upd_req,
  input logic [UOP_W-1:0] rob_rsv_count,
  input logic [SW-1:0]    disp_evt_uops,
  input logic             part_evt_valid,
  input logic [SW-1:0]    part_evt_uops,
  input logic [SW-1:0]    avail_slots,
  input logic             carry_pending
);

  p_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (disp_evt_uops <= avail_slots) && (disp_evt_uops != '0));

  p_stall_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_code != 2'b00) |-> (in_valid && !in_ready));

  p_stall_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_code != 2'b11);

  p_rob_before_rf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_code == 2'b10) |-> (int'(rob_free) >= int'(in_uops)));

  p_next_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !next_rdy |-> !fwd_valid);

  p_full_budget_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwd_valid && !carry_pending) |=> (int'(avail_slots) == W) && !part_evt_valid);

  p_carry_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && int'(rob_rsv_count) > W) |=> part_evt_valid &&
      (int'(part_evt_uops) == ((int'($past(rob_rsv_count)) - W >= W) ? W
                                : int'($past(rob_rsv_count)) - W)));

  p_part_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    part_evt_valid |-> (int'(part_evt_uops) + int'(avail_slots) == W));

  p_no_over_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    carry_pending |-> !(fwd_valid && int'(rob_rsv_count) > W));

  p_dep_break_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dep_upd_req |-> (fwd_valid && !in_dep_break));

endmodule

bind uop_dispatch_gate uop_dispatch_gate_chk #(
  .W(W), .UOP_W(UOP_W), .ID_W(ID_W), .ROB_W(ROB_W), .SW(SW)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_uops        (in_uops),
  .in_dep_break   (in_dep_break),
  .rob_free       (rob_free),
  .next_rdy       (next_rdy),
  .in_ready       (in_ready),
  .stall_code     (stall_code),
  .fwd_valid      (fwd_valid),
  .dep_upd_req    (dep_upd_req),
  .rob_rsv_count  (rob_rsv_count),
  .disp_evt_uops  (disp_evt_uops),
  .part_evt_valid (part_evt_valid),
  .part_evt_uops  (part_evt_uops),
  .avail_slots    (avail_slots),
  .carry_pending  (carry_pending)
);

// File: tb/uop_dispatch_gate_test.sv
module uop_dispatch_gate_test;

  localparam int CLK_P    = 10;
  localparam int NROWS    = 18;
  localparam int WD_LIMIT = 2000;

  typedef struct packed {
    logic       v;
    logic [3:0] u;
    logic       db;
    logic [4:0] rob;
    logic       rfok;
    logic       nx;
    logic       acc;
    logic [1:0] st;
    logic [2:0] evt;
    logic [3:0] rsv;
    logic [2:0] av;
    logic       pv;
    logic [2:0] pu;
    logic       pend;
    logic       dep;
    logic [7:0] pid;
  } row_t;

  function automatic row_t mk(int v, int u, int db, int rob, int rfok, int nx,
                              int acc, int st, int evt, int rsv, int av,
                              int pv, int pu, int pend, int dep, int pid);
    row_t r;
    r.v = 1'(v);   r.u = 4'(u);     r.db = 1'(db);  r.rob = 5'(rob);
    r.rfok = 1'(rfok); r.nx = 1'(nx); r.acc = 1'(acc); r.st = 2'(st);
    r.evt = 3'(evt); r.rsv = 4'(rsv); r.av = 3'(av); r.pv = 1'(pv);
    r.pu = 3'(pu); r.pend = 1'(pend); r.dep = 1'(dep); r.pid = 8'(pid);
    return r;
  endfunction

  // Rows run back to back; in_id equals the row index. W = 4.
  //                     v  u db rob rf nx | acc st evt rsv av pv pu pend dep pid
  localparam row_t TBL [NROWS] = '{
    mk(0, 0, 0,  8, 1, 1,   0, 0, 0, 0, 4, 0, 0, 0, 0,  0),  // idle, R2
    mk(1, 2, 0,  8, 1, 1,   1, 0, 2, 2, 4, 0, 0, 0, 1,  0),  // R6 R10
    mk(1, 3, 1,  8, 1, 1,   1, 0, 3, 3, 4, 0, 0, 0, 0,  0),  // R2 R10 dep-break
    mk(1, 0, 0,  8, 1, 1,   1, 0, 1, 1, 4, 0, 0, 0, 1,  0),  // R3 zero uops
    mk(1, 2, 0,  1, 1, 1,   0, 1, 0, 0, 4, 0, 0, 0, 0,  0),  // R4 retire
    mk(1, 2, 0,  1, 0, 1,   0, 1, 0, 0, 4, 0, 0, 0, 0,  0),  // R4 priority
    mk(1, 2, 0,  8, 0, 1,   0, 2, 0, 0, 4, 0, 0, 0, 0,  0),  // R4 regfile
    mk(1, 2, 0,  8, 1, 0,   0, 0, 0, 0, 4, 0, 0, 0, 0,  0),  // R5
    mk(1, 6, 0,  8, 1, 1,   1, 0, 4, 6, 4, 0, 0, 0, 1,  0),  // R7 carry 2
    mk(1, 2, 0,  8, 1, 1,   1, 0, 2, 2, 2, 1, 2, 0, 1,  8),  // R8 shares cycle
    mk(1,12, 0, 16, 1, 1,   1, 0, 4,12, 4, 0, 0, 0, 1,  0),  // R7 carry 8
    mk(1, 1, 0,  8, 1, 1,   0, 0, 0, 0, 0, 1, 4, 1, 0, 10),  // R8 R9 budget 0
    mk(1, 5, 0,  8, 1, 1,   0, 0, 0, 0, 0, 1, 4, 0, 0, 10),  // R8 last charge
    mk(1, 3, 0,  8, 1, 1,   1, 0, 3, 3, 4, 0, 0, 0, 1,  0),  // R9 back to full
    mk(1, 7, 0,  6, 1, 1,   0, 1, 0, 0, 4, 0, 0, 0, 0,  0),  // R4 retire room
    mk(1, 7, 0,  7, 1, 1,   1, 0, 4, 7, 4, 0, 0, 0, 1,  0),  // R7 carry 3
    mk(1, 5, 0,  8, 1, 1,   0, 0, 0, 0, 1, 1, 3, 0, 0, 15),  // R3 R9 oversized blocked
    mk(1, 1, 1,  8, 1, 1,   1, 0, 1, 1, 4, 0, 0, 0, 0,  0)   // R2 R10
  };

  logic       clk, rst_n;
  logic       in_valid, in_dep_break, rf_ok, next_rdy;
  logic [3:0] in_uops;
  logic [7:0] in_id;
  logic [4:0] rob_free;
  logic       in_ready, fwd_valid, dep_upd_req, part_evt_valid, carry_pending;
  logic [1:0] stall_code;
  logic [7:0] fwd_id, part_evt_id;
  logic [3:0] rob_rsv_count;
  logic [2:0] disp_evt_uops, part_evt_uops, avail_slots;

  int n_chk, n_fail, cyc;
  bit done;

  uop_dispatch_gate uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
    .in_id(in_id), .in_dep_break(in_dep_break), .rob_free(rob_free),
    .rf_ok(rf_ok), .next_rdy(next_rdy), .in_ready(in_ready),
    .stall_code(stall_code), .fwd_valid(fwd_valid), .fwd_id(fwd_id),
    .dep_upd_req(dep_upd_req), .rob_rsv_count(rob_rsv_count),
    .disp_evt_uops(disp_evt_uops), .part_evt_valid(part_evt_valid),
    .part_evt_uops(part_evt_uops), .part_evt_id(part_evt_id),
    .avail_slots(avail_slots), .carry_pending(carry_pending)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic drive(int v, int u, int id, int db, int rob, int rfok, int nx);
    in_valid = 1'(v); in_uops = 4'(u); in_id = 8'(id); in_dep_break = 1'(db);
    rob_free = 5'(rob); rf_ok = 1'(rfok); next_rdy = 1'(nx);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WD_LIMIT) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WD_LIMIT);
        finish_run();
      end
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 8, 1, 1);
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset avail", int'(avail_slots), 4);
    chk("R1 reset pending", int'(carry_pending), 0);
    chk("R1 reset partial", int'(part_evt_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      drive(int'(TBL[i].v), int'(TBL[i].u), i, int'(TBL[i].db),
            int'(TBL[i].rob), int'(TBL[i].rfok), int'(TBL[i].nx));
      #1;
      chk($sformatf("R3 accept row %0d", i), int'(fwd_valid), int'(TBL[i].acc));
      chk($sformatf("R4 stall row %0d", i), int'(stall_code), int'(TBL[i].st));
      chk($sformatf("R6 event row %0d", i), int'(disp_evt_uops), int'(TBL[i].evt));
      chk($sformatf("R6 reserve row %0d", i), int'(rob_rsv_count), int'(TBL[i].rsv));
      chk($sformatf("R8 avail row %0d", i), int'(avail_slots), int'(TBL[i].av));
      chk($sformatf("R8 partial row %0d", i), int'(part_evt_valid), int'(TBL[i].pv));
      chk($sformatf("R8 partial uops row %0d", i), int'(part_evt_uops), int'(TBL[i].pu));
      chk($sformatf("R9 pending row %0d", i), int'(carry_pending), int'(TBL[i].pend));
      chk($sformatf("R10 dep row %0d", i), int'(dep_upd_req), int'(TBL[i].dep));
      if (TBL[i].pv)
        chk($sformatf("R8 partial id row %0d", i), int'(part_evt_id), int'(TBL[i].pid));
      if (TBL[i].acc)
        chk($sformatf("R6 fwd id row %0d", i), int'(fwd_id), i);
    end

    // R7: 15 micro-ops leave 11 to carry; next cycle charges 4.
    @(negedge clk);
    drive(1, 15, 8'h5A, 0, 20, 1, 1);
    #1;
    chk("R7 accept 15", int'(fwd_valid), 1);
    chk("R7 event width", int'(disp_evt_uops), 4);
    @(negedge clk);
    drive(0, 0, 0, 0, 8, 1, 1);
    #1;
    chk("R8 charge 4", int'(part_evt_uops), 4);
    chk("R8 held id", int'(part_evt_id), 8'h5A);
    chk("R9 pending after first charge", int'(carry_pending), 1);

    // R1: reset in the middle of a carry-over discards it.
    #2;
    rst_n = 1'b0;
    #1;
    chk("R1 async avail", int'(avail_slots), 4);
    chk("R1 async partial", int'(part_evt_valid), 0);
    chk("R1 async pending", int'(carry_pending), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 carry discarded avail", int'(avail_slots), 4);
    chk("R1 carry discarded partial", int'(part_evt_valid), 0);

    finish_run();
  end

endmodule